// File: doc/BRIEF.md
# Dual Byte FIFO with Threshold Ready and Self-Clearing Flush

This block holds the transmit and receive byte queues that sit between a register interface and a byte-serial shifter. On the register side, whole words are pushed into the transmit queue and popped from the receive queue. On the shifter side, single bytes are taken from the transmit queue and placed into the receive queue. Words are little-endian: the byte in bits 7:0 is the first byte to reach, or the first byte to come from, the serial side. A mode input narrows each register access to a single byte.

Each queue has its own ready flag, compared against a 3-bit threshold. Receive-ready tracks how much the queue holds. Transmit-ready tracks how much room is left. Each queue also reports full and empty, and keeps sticky flags for overflow and underflow.

A flush request empties both queues, clears the sticky flags, and then drops by itself. A synchronous soft reset returns everything to the initial state at once. Neither the shifter nor the register decode is part of this block.

Top module: `tfq_dual_fifo`

## Requirements
- R1: In word mode (`word4`=1), a register push places four bytes in the transmit queue. `sh_tx_byte` then presents them in the order bits 7:0, 15:8, 23:16, 31:24.
- R2: In word mode, `rd_word` shows the next four received bytes. The oldest byte is in bits 7:0 and the newest in bits 31:24. A pop removes all four.
- R3: In byte mode (`word4`=0), a register push enqueues only bits 7:0 of `wr_word`, and a register pop removes one byte. `rd_word` then carries that byte in bits 7:0 with bits 31:8 at zero.
- R4: `rx_rdy` is 1 exactly when the number of bytes held in the receive queue is greater than `rx_thr`.
- R5: `tx_rdy` is 1 exactly when the number of free byte slots in the transmit queue (depth 8) is greater than `tx_thr`.
- R6: `*_full` is 1 when a queue holds 8 bytes, and `*_empty` is 1 when it holds none.
- R7: A push that needs more room than is free enqueues nothing and sets the sticky overflow flag of that queue. This applies to a register word push and to a shifter byte push.
- R8: A pop that asks for more bytes than are held removes nothing and sets the sticky underflow flag of that queue. While that pop is asked for, the data seen on `rd_word` or `sh_tx_byte` is 0.
- R9: After a `flush_req` pulse, `flush_busy` is 1 from the next cycle. On the following edge both queues are emptied and all sticky flags cleared. `flush_busy` returns to 0 on the first edge at which it is high and both queues are already empty.
- R10: `rst` or `srst` puts the block in its initial state: both queues empty, no sticky flags, `flush_busy` low, and `tx_rdy` high.
- R11: While `flush_busy` is 1, pushes and pops on both sides have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| srst | input | 1 | Synchronous soft reset of queues and status |
| word4 | input | 1 | 1: four-byte register accesses, 0: single byte |
| rx_thr | input | 3 | Receive-ready threshold |
| tx_thr | input | 3 | Transmit-ready threshold |
| flush_req | input | 1 | Pulse to start a flush |
| flush_busy | output | 1 | Flush in progress, clears itself |
| wr_push | input | 1 | Register-side push into the transmit queue |
| wr_word | input | 32 | Word to push |
| rd_pop | input | 1 | Register-side pop from the receive queue |
| rd_word | output | 32 | Next receive word, 0 when too few bytes |
| sh_tx_pop | input | 1 | Shifter takes one transmit byte |
| sh_tx_byte | output | 8 | Head of the transmit queue, 0 when empty |
| sh_rx_push | input | 1 | Shifter delivers one receive byte |
| sh_rx_byte | input | 8 | Received byte |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_rdy | output | 1 | Transmit room above threshold |
| tx_ovf | output | 1 | Sticky transmit overflow |
| tx_udf | output | 1 | Sticky transmit underflow |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_rdy | output | 1 | Receive fill above threshold |
| rx_ovf | output | 1 | Sticky receive overflow |
| rx_udf | output | 1 | Sticky receive underflow |

## Verification
The hardest case to reach from the ports is an access made while a flush is running. The queues are already empty by that cycle, so a push that is wrongly accepted only shows up once `flush_busy` has dropped. The stimulus fills both queues and pulses `flush_req`. In the cycle after the queues empty, while `flush_busy` is still high, it pushes on both sides. It then checks that the queues are still empty once the flush has ended. Partial-word pops are reached by filling the receive queue to three bytes in word mode. The full-queue overflow is reached by pushing a third word after two.

// File: rtl/tfq_pkg.sv
package tfq_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = BYTE_W * LANES;
    localparam int THR_W  = 3;
    localparam int LN_W   = $clog2(LANES + 1);

    typedef enum logic {
        WM_BYTE = 1'b0,
        WM_WORD = 1'b1
    } word_mode_e;

    typedef struct packed {
        logic full;
        logic empty;
        logic ready;
        logic ovf;
        logic udf;
    } fifo_stat_t;

    function automatic logic [LN_W-1:0] lane_count(input word_mode_e m);
        return (m == WM_WORD) ? LN_W'(LANES) : LN_W'(1);
    endfunction

    function automatic logic [WORD_W-1:0] lane_mask(input word_mode_e m,
                                                    input logic [WORD_W-1:0] w);
        return (m == WM_WORD) ? w : {{(WORD_W-BYTE_W){1'b0}}, w[BYTE_W-1:0]};
    endfunction
endpackage

// File: rtl/tfq_byte_fifo.sv
// Byte queue with a multi-byte push and a multi-byte pop each cycle.
// DEPTH must be a power of two.
module tfq_byte_fifo
    import tfq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push_req,
    input  logic [LN_W-1:0]   push_n,
    input  logic [WORD_W-1:0] push_data,
    input  logic              pop_req,
    input  logic [LN_W-1:0]   pop_n,
    output logic [WORD_W-1:0] peek,
    output logic [CW-1:0]     level,
    output logic              ovf_sticky,
    output logic              udf_sticky
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     level_q;
    logic [CW-1:0]     push_cnt, pop_cnt, room;
    logic              push_ok, push_bad, pop_ok, pop_bad;

    assign push_cnt = CW'(push_n);
    assign pop_cnt  = CW'(pop_n);
    assign room     = CW'(DEPTH) - level_q;
    assign push_ok  = push_req && (push_cnt <= room);
    assign push_bad = push_req && (push_cnt >  room);
    assign pop_ok   = pop_req  && (pop_cnt  <= level_q);
    assign pop_bad  = pop_req  && (pop_cnt  >  level_q);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr     <= '0;
            rd_ptr     <= '0;
            level_q    <= '0;
            ovf_sticky <= 1'b0;
            udf_sticky <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + PW'(push_n);
            if (pop_ok)  rd_ptr <= rd_ptr + PW'(pop_n);
            level_q <= level_q + (push_ok ? push_cnt : '0) - (pop_ok ? pop_cnt : '0);
            if (push_bad) ovf_sticky <= 1'b1;
            if (pop_bad)  udf_sticky <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !rst && !clr) begin
            for (int i = 0; i < LANES; i++) begin
                if (CW'(i) < push_cnt)
                    mem[wr_ptr + PW'(i)] <= push_data[i*BYTE_W +: BYTE_W];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            peek[i*BYTE_W +: BYTE_W] = (CW'(i) < level_q) ? mem[rd_ptr + PW'(i)] : '0;
        end
    end

    assign level = level_q;
endmodule

// File: rtl/tfq_level_flags.sv
// Full / empty / ready decode; FREE_BASED picks room-vs-threshold or fill-vs-threshold.
module tfq_level_flags
    import tfq_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int CW         = $clog2(DEPTH + 1),
    parameter bit FREE_BASED = 1'b0
) (
    input  logic [CW-1:0]    level,
    input  logic [THR_W-1:0] thr,
    input  logic             ovf,
    input  logic             udf,
    output fifo_stat_t       stat
);
    assign stat.full  = (level == CW'(DEPTH));
    assign stat.empty = (level == '0);
    assign stat.ovf   = ovf;
    assign stat.udf   = udf;

    generate
        if (FREE_BASED) begin : g_room
            assign stat.ready = (CW'(DEPTH) - level) > CW'(thr);
        end else begin : g_fill
            assign stat.ready = level > CW'(thr);
        end
    endgenerate
endmodule

// File: rtl/tfq_flush_seq.sv
// Flush bit: set by request, cleared once both queues read as empty.
module tfq_flush_seq (
    input  logic clk,
    input  logic rst,
    input  logic srst,
    input  logic flush_req,
    input  logic both_empty,
    output logic busy
);
    always_ff @(posedge clk) begin
        if (rst || srst)             busy <= 1'b0;
        else if (flush_req)          busy <= 1'b1;
        else if (busy && both_empty) busy <= 1'b0;
    end
endmodule

// File: rtl/tfq_dual_fifo.sv
module tfq_dual_fifo
    import tfq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              srst,
    input  logic              word4,
    input  logic [THR_W-1:0]  rx_thr,
    input  logic [THR_W-1:0]  tx_thr,
    input  logic              flush_req,
    output logic              flush_busy,
    input  logic              wr_push,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_pop,
    output logic [WORD_W-1:0] rd_word,
    input  logic              sh_tx_pop,
    output logic [BYTE_W-1:0] sh_tx_byte,
    input  logic              sh_rx_push,
    input  logic [BYTE_W-1:0] sh_rx_byte,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              tx_rdy,
    output logic              tx_ovf,
    output logic              tx_udf,
    output logic              rx_full,
    output logic              rx_empty,
    output logic              rx_rdy,
    output logic              rx_ovf,
    output logic              rx_udf
);
    localparam int CW = $clog2(DEPTH + 1);

    word_mode_e        mode;
    logic [LN_W-1:0]   need;
    logic              gate, clr;
    logic [WORD_W-1:0] tx_peek, rx_peek;
    logic [CW-1:0]     tx_level, rx_level;
    logic              tx_ovf_i, tx_udf_i, rx_ovf_i, rx_udf_i;
    fifo_stat_t        tx_stat, rx_stat;

    assign mode = word_mode_e'(word4);
    assign need = lane_count(mode);
    assign gate = !flush_busy;
    assign clr  = srst || flush_busy;

    tfq_byte_fifo #(.DEPTH(DEPTH), .CW(CW)) u_tx (
        .clk(clk), .rst(rst), .clr(clr),
        .push_req(wr_push && gate), .push_n(need), .push_data(wr_word),
        .pop_req(sh_tx_pop && gate), .pop_n(LN_W'(1)),
        .peek(tx_peek), .level(tx_level),
        .ovf_sticky(tx_ovf_i), .udf_sticky(tx_udf_i)
    );

    tfq_byte_fifo #(.DEPTH(DEPTH), .CW(CW)) u_rx (
        .clk(clk), .rst(rst), .clr(clr),
        .push_req(sh_rx_push && gate), .push_n(LN_W'(1)),
        .push_data({{(WORD_W-BYTE_W){1'b0}}, sh_rx_byte}),
        .pop_req(rd_pop && gate), .pop_n(need),
        .peek(rx_peek), .level(rx_level),
        .ovf_sticky(rx_ovf_i), .udf_sticky(rx_udf_i)
    );

    tfq_level_flags #(.DEPTH(DEPTH), .CW(CW), .FREE_BASED(1'b1)) u_tx_flags (
        .level(tx_level), .thr(tx_thr), .ovf(tx_ovf_i), .udf(tx_udf_i), .stat(tx_stat)
    );

    tfq_level_flags #(.DEPTH(DEPTH), .CW(CW), .FREE_BASED(1'b0)) u_rx_flags (
        .level(rx_level), .thr(rx_thr), .ovf(rx_ovf_i), .udf(rx_udf_i), .stat(rx_stat)
    );

    tfq_flush_seq u_flush (
        .clk(clk), .rst(rst), .srst(srst), .flush_req(flush_req),
        .both_empty(tx_stat.empty && rx_stat.empty), .busy(flush_busy)
    );

    assign rd_word    = (rx_level >= CW'(need)) ? lane_mask(mode, rx_peek) : '0;
    assign sh_tx_byte = tx_peek[BYTE_W-1:0];

    assign {tx_full, tx_empty, tx_rdy, tx_ovf, tx_udf} = tx_stat;
    assign {rx_full, rx_empty, rx_rdy, rx_ovf, rx_udf} = rx_stat;
endmodule

// File: rtl/tfq_dual_fifo_chk.sv
module tfq_dual_fifo_chk (
    input logic        clk,
    input logic        rst,
    input logic        srst,
    input logic        word4,
    input logic        flush_req,
    input logic        flush_busy,
    input logic        rd_pop,
    input logic [31:0] rd_word,
    input logic        tx_full,
    input logic        tx_empty,
    input logic        tx_rdy,
    input logic        tx_ovf,
    input logic        rx_empty,
    input logic        rx_rdy,
    input logic        rx_udf
);
    AST_TX_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (rst) !(tx_full && tx_empty)); // R6
    AST_RX_RDY_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst) rx_empty |-> !rx_rdy); // R4
    AST_TX_RDY_NEEDS_ROOM: assert property (@(posedge clk) disable iff (rst) tx_full |-> !tx_rdy); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) tx_ovf && !flush_busy && !srst |=> tx_ovf); // R7
    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (rst) rx_udf && !flush_busy && !srst |=> rx_udf); // R8
    AST_UDF_READS_ZERO: assert property (@(posedge clk) disable iff (rst) rd_pop && rx_empty |-> rd_word == 32'h0); // R8
    AST_BYTE_MODE_UPPER: assert property (@(posedge clk) disable iff (rst) !word4 |-> rd_word[31:8] == 24'h0); // R3
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst) flush_busy |=> tx_empty && rx_empty); // R9
    AST_FLUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst) flush_busy && tx_empty && rx_empty && !flush_req |=> !flush_busy); // R9
    AST_SRST_INIT: assert property (@(posedge clk) disable iff (rst) srst |=> tx_empty && rx_empty && !tx_ovf && !rx_udf && !flush_busy); // R10
endmodule

bind tfq_dual_fifo tfq_dual_fifo_chk u_chk (.*);

// File: tb/tb_tfq_dual_fifo.sv
module tb_tfq_dual_fifo;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst, srst, word4, flush_req, flush_busy;
    logic [2:0]  rx_thr, tx_thr;
    logic        wr_push, rd_pop, sh_tx_pop, sh_rx_push;
    logic [31:0] wr_word, rd_word;
    logic [7:0]  sh_tx_byte, sh_rx_byte;
    logic        tx_full, tx_empty, tx_rdy, tx_ovf, tx_udf;
    logic        rx_full, rx_empty, rx_rdy, rx_ovf, rx_udf;

    tfq_dual_fifo dut (.*);

    int checks = 0;
    int errors = 0;

    localparam logic [3:0] OP_MODE = 4'd0, OP_WR = 4'd1, OP_TXB = 4'd2,
                           OP_RXB = 4'd3, OP_RD = 4'd4, OP_FLG = 4'd5;
    // flag vector: {tx_full,tx_empty,tx_rdy,tx_ovf,tx_udf, rx_full,rx_empty,rx_rdy,rx_ovf,rx_udf}
    localparam logic [31:0] RESET_FLAGS = 32'b01100_01000;
    localparam int NV = 54;
    localparam logic [71:0] VEC [NV] = '{
        {OP_MODE, 32'h00000331, 32'h0, 4'd0},
        {OP_FLG,  32'h0, 32'b01100_01000, 4'd10}, // R10
        {OP_WR,   32'h44332211, 32'h0, 4'd1},     // R1
        {OP_FLG,  32'h0, 32'b00100_01000, 4'd5},  // R5
        {OP_WR,   32'h88776655, 32'h0, 4'd1},     // R1
        {OP_FLG,  32'h0, 32'b10000_01000, 4'd6},  // R6
        {OP_WR,   32'hDEADBEEF, 32'h0, 4'd7},     // R7
        {OP_FLG,  32'h0, 32'b10010_01000, 4'd7},  // R7
        {OP_TXB,  32'h0, 32'h11, 4'd1},           // R1
        {OP_TXB,  32'h0, 32'h22, 4'd1},
        {OP_TXB,  32'h0, 32'h33, 4'd1},
        {OP_TXB,  32'h0, 32'h44, 4'd1},
        {OP_TXB,  32'h0, 32'h55, 4'd1},
        {OP_TXB,  32'h0, 32'h66, 4'd1},
        {OP_TXB,  32'h0, 32'h77, 4'd1},
        {OP_TXB,  32'h0, 32'h88, 4'd1},
        {OP_FLG,  32'h0, 32'b01110_01000, 4'd6},  // R6
        {OP_TXB,  32'h0, 32'h00, 4'd8},           // R8
        {OP_FLG,  32'h0, 32'b01111_01000, 4'd8},  // R8
        {OP_RXB,  32'hA1, 32'h0, 4'd2},
        {OP_RXB,  32'hB2, 32'h0, 4'd2},
        {OP_RXB,  32'hC3, 32'h0, 4'd2},
        {OP_FLG,  32'h0, 32'b01111_00000, 4'd4},  // R4
        {OP_RD,   32'h0, 32'h0, 4'd8},            // R8
        {OP_FLG,  32'h0, 32'b01111_00001, 4'd8},  // R8
        {OP_RXB,  32'hD4, 32'h0, 4'd2},
        {OP_FLG,  32'h0, 32'b01111_00101, 4'd4},  // R4
        {OP_RD,   32'h0, 32'hD4C3B2A1, 4'd2},     // R2
        {OP_FLG,  32'h0, 32'b01111_01001, 4'd2},  // R2
        {OP_RXB,  32'h01, 32'h0, 4'd6},
        {OP_RXB,  32'h02, 32'h0, 4'd6},
        {OP_RXB,  32'h03, 32'h0, 4'd6},
        {OP_RXB,  32'h04, 32'h0, 4'd6},
        {OP_RXB,  32'h05, 32'h0, 4'd6},
        {OP_RXB,  32'h06, 32'h0, 4'd6},
        {OP_RXB,  32'h07, 32'h0, 4'd6},
        {OP_RXB,  32'h08, 32'h0, 4'd6},
        {OP_FLG,  32'h0, 32'b01111_10101, 4'd6},  // R6
        {OP_RXB,  32'h09, 32'h0, 4'd7},
        {OP_FLG,  32'h0, 32'b01111_10111, 4'd7},  // R7
        {OP_RD,   32'h0, 32'h04030201, 4'd2},     // R2
        {OP_RD,   32'h0, 32'h08070605, 4'd2},
        {OP_MODE, 32'h00000600, 32'h0, 4'd0},
        {OP_WR,   32'hFFFFFF5A, 32'h0, 4'd3},     // R3
        {OP_FLG,  32'h0, 32'b00111_01011, 4'd5},  // R5
        {OP_WR,   32'h000000A5, 32'h0, 4'd3},     // R3
        {OP_FLG,  32'h0, 32'b00011_01011, 4'd5},  // R5
        {OP_TXB,  32'h0, 32'h5A, 4'd3},           // R3
        {OP_TXB,  32'h0, 32'hA5, 4'd3},
        {OP_RXB,  32'h7E, 32'h0, 4'd3},
        {OP_FLG,  32'h0, 32'b01111_00111, 4'd4},  // R4
        {OP_RD,   32'h0, 32'h0000007E, 4'd3},     // R3
        {OP_RD,   32'h0, 32'h0, 4'd8},            // R8
        {OP_FLG,  32'h0, 32'b01111_01011, 4'd8}   // R8
    };

    function automatic logic [31:0] flags();
        return {22'h0, tx_full, tx_empty, tx_rdy, tx_ovf, tx_udf,
                rx_full, rx_empty, rx_rdy, rx_ovf, rx_udf};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_push = 0; rd_pop = 0; sh_tx_pop = 0; sh_rx_push = 0;
        flush_req = 0; srst = 0;
    endtask

    logic [3:0]  v_op, v_req;
    logic [31:0] v_arg, v_exp;

    initial begin
        rst = 1; idle(); word4 = 1; rx_thr = 3; tx_thr = 3;
        wr_word = 0; sh_rx_byte = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;

        for (int k = 0; k < NV; k++) begin
            {v_op, v_arg, v_exp, v_req} = VEC[k];
            @(negedge clk);
            idle();
            case (v_op)
                OP_MODE: begin word4 = v_arg[0]; rx_thr = v_arg[6:4]; tx_thr = v_arg[10:8]; end
                OP_WR:   begin wr_push = 1; wr_word = v_arg; end
                OP_TXB:  begin #1 check($sformatf("R%0d", v_req), {24'h0, sh_tx_byte}, v_exp); sh_tx_pop = 1; end
                OP_RXB:  begin sh_rx_push = 1; sh_rx_byte = v_arg[7:0]; end
                OP_RD:   begin #1 check($sformatf("R%0d", v_req), rd_word, v_exp); rd_pop = 1; end
                default: check($sformatf("R%0d", v_req), flags(), v_exp);
            endcase
        end

        // Flush sequence, byte mode, thresholds 0/6 (R9, R11)
        @(negedge clk) idle(); wr_push = 1; wr_word = 32'h3C; sh_rx_push = 1; sh_rx_byte = 8'h4D;
        @(negedge clk) idle(); flush_req = 1;
        @(negedge clk) idle();
        check("R9", {31'h0, flush_busy}, 32'h1);
        check("R9", {31'h0, tx_empty}, 32'h0);
        @(negedge clk);
        check("R9", {31'h0, flush_busy}, 32'h1);
        check("R9", flags(), 32'b01100_01000);
        wr_push = 1; wr_word = 32'h77; sh_rx_push = 1; sh_rx_byte = 8'h66; rd_pop = 1; // R11
        @(negedge clk) idle();
        check("R9", {31'h0, flush_busy}, 32'h0);
        check("R11", flags(), 32'b01100_01000);
        check("R11", {24'h0, sh_tx_byte}, 32'h0);

        // Soft reset (R10)
        @(negedge clk) wr_push = 1; wr_word = 32'h12;
        @(negedge clk) idle(); rd_pop = 1;
        @(negedge clk) idle();
        check("R8", {31'h0, rx_udf}, 32'h1);
        srst = 1;
        @(negedge clk) idle();
        check("R10", flags(), RESET_FLAGS);
        check("R10", {31'h0, flush_busy}, 32'h0);

        // Hard reset with data and a pending flush (R10)
        @(negedge clk) sh_rx_push = 1; sh_rx_byte = 8'h99;
        @(negedge clk) idle(); flush_req = 1; rst = 1;
        @(negedge clk) idle();
        @(negedge clk) rst = 0;
        check("R10", flags(), RESET_FLAGS);
        check("R10", {31'h0, flush_busy}, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule